// File: doc/BRIEF.md
# Semi-Synchronous Read Bus Master

This block runs read cycles on a parallel bus for a core. Each cycle has four fixed clock periods: T1, T2, T3 and T4. A slave that needs more time can stretch the cycle by holding its ready line low. The master then inserts extra Tw periods between T2 and T3.

The core pulses a start request together with an address. The master places that address on the bus in T1 and raises the read strobe in T2. After T2 it samples the slave's ready line once per period. Each low sample costs one Tw period, and a high sample moves the cycle to T3. During T3 the master loads the bus data into its result register. In T4 it drops the strobe and reports the result to the core with a one-cycle valid pulse.

A parameter bounds the number of Tw periods. A slave that stays not-ready past that bound causes the cycle to abort through T4 with a one-cycle error pulse instead of a valid pulse.

Top module: `ssb_rd_master`

## Requirements
- R1: While reset is asserted, and after it is released, busy, read strobe, valid and error are low, and the bus address and the result are zero.
- R2: A start request seen in an idle cycle begins T1 at the next clock edge. In T1 the requested address is on the bus, busy is high and the read strobe is low.
- R3: The read strobe is high in T2, in every Tw period and in T3, and low in T1 and T4.
- R4: A ready line that is already high when T2 ends gives zero wait states, so T3 follows T2 directly.
- R5: Each low sample of the ready line at the end of T2 or of a Tw period inserts exactly one further Tw period, up to MAX_WAIT periods.
- R6: The result register loads the bus data at the end of T3 and holds it until the next completed read. Data driven at any other time is not taken.
- R7: The valid output is high for exactly one cycle, T4, after a completed read, and the read strobe is low in that cycle.
- R8: Busy is high for 4+n cycles for a read with n wait states and falls in the cycle after T4.
- R9: If the ready line is low at the end of T2 and at the end of all MAX_WAIT Tw periods, the cycle moves to T4 with the error output high for that one cycle. In that case valid stays low and the result register keeps its old value, and busy lasts 3+MAX_WAIT cycles.
- R10: A start request seen while busy is high, T4 included, is ignored. The bus address does not change and no second cycle follows.
- R11: The bus address is held unchanged from T1 through T4 and is zero while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Read request from the core |
| addr_i | input | AW | Address to read, sampled with start_i |
| busy_o | output | 1 | A read cycle is in progress |
| rdata_o | output | DW | Last completed read data |
| valid_o | output | 1 | One-cycle pulse: rdata_o was just updated |
| err_o | output | 1 | One-cycle pulse: the cycle aborted on the wait limit |
| bus_addr_o | output | AW | Address bus |
| bus_rd_o | output | 1 | Read command strobe |
| bus_wait_i | input | 1 | Slave ready: low requests a further Tw period |
| bus_data_i | input | DW | Data bus from the slave |

## Verification
The bench sweeps the number of wait states from zero through the limit and two past it. It checks every signal in every cycle against a timeline worked out from the wait count. A design that sampled ready one period late would add a wait state on zero-wait reads. An off-by-one limit would either abort the read that needs exactly MAX_WAIT periods or allow one period too many.

The slave drives a marker value whenever it is not ready, so a result taken before T3 shows up as that marker. Start pulses are injected in T2 and in T4. A design that accepted either of them would change the bus address or start a second cycle.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_TW   = 3'd3,
    PH_T3   = 3'd4,
    PH_T4   = 3'd5
  } phase_e;
endpackage

// File: rtl/ssb_rst_sync.sv
module ssb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sr_q[STAGES-1];
endmodule

// File: rtl/ssb_wait_ctr.sv
module ssb_wait_ctr #(
  parameter int MAX_WAIT = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int CW = (MAX_WAIT < 1) ? 1 : $clog2(MAX_WAIT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_WAIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign at_limit = (cnt_q == LIMIT);
endmodule

// File: rtl/ssb_phase_fsm.sv
module ssb_phase_fsm
  import ssb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   slv_ready,
  input  logic   at_limit,
  output phase_e phase,
  output logic   accept,
  output logic   ctr_clr,
  output logic   ctr_inc,
  output logic   capture,
  output logic   abort_evt
);
  phase_e ph_q, ph_d;
  logic   sampling;

  always_comb begin
    sampling  = (ph_q == PH_T2) || (ph_q == PH_TW);
    accept    = (ph_q == PH_IDLE) && start;
    ctr_clr   = (ph_q == PH_T1);
    ctr_inc   = sampling && !slv_ready && !at_limit;
    abort_evt = sampling && !slv_ready && at_limit;
    capture   = (ph_q == PH_T3);
  end

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE: if (start) ph_d = PH_T1;
      PH_T1:   ph_d = PH_T2;
      PH_T2,
      PH_TW: begin
        if (slv_ready)     ph_d = PH_T3;
        else if (at_limit) ph_d = PH_T4;
        else               ph_d = PH_TW;
      end
      PH_T3:   ph_d = PH_T4;
      PH_T4:   ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  assign phase = ph_q;
endmodule

// File: rtl/ssb_rd_datapath.sv
module ssb_rd_datapath #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          capture,
  input  logic          abort_evt,
  input  logic          drive_addr,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] bus_data,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] rdata,
  output logic          valid,
  output logic          err
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] rdata_q;
  logic          valid_q, err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (accept) addr_q <= addr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= bus_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= capture;
      err_q   <= abort_evt;
    end
  end

  assign bus_addr = drive_addr ? addr_q : '0;
  assign rdata    = rdata_q;
  assign valid    = valid_q;
  assign err      = err_q;
endmodule

// File: rtl/ssb_rd_master.sv
module ssb_rd_master
  import ssb_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int MAX_WAIT = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  output logic          busy_o,
  output logic [DW-1:0] rdata_o,
  output logic          valid_o,
  output logic          err_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_rd_o,
  input  logic          bus_wait_i,
  input  logic [DW-1:0] bus_data_i
);
  logic   rst_n_int;
  phase_e phase;
  logic   accept, ctr_clr, ctr_inc, capture, abort_evt, at_limit;
  logic   busy;

  ssb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  ssb_phase_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .start     (start_i),
    .slv_ready (bus_wait_i),
    .at_limit  (at_limit),
    .phase     (phase),
    .accept    (accept),
    .ctr_clr   (ctr_clr),
    .ctr_inc   (ctr_inc),
    .capture   (capture),
    .abort_evt (abort_evt)
  );

  ssb_wait_ctr #(.MAX_WAIT(MAX_WAIT)) u_wctr (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .clr      (ctr_clr),
    .inc      (ctr_inc),
    .at_limit (at_limit)
  );

  assign busy = (phase != PH_IDLE);

  ssb_rd_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .accept     (accept),
    .capture    (capture),
    .abort_evt  (abort_evt),
    .drive_addr (busy),
    .addr_in    (addr_i),
    .bus_data   (bus_data_i),
    .bus_addr   (bus_addr_o),
    .rdata      (rdata_o),
    .valid      (valid_o),
    .err        (err_o)
  );

  assign busy_o   = busy;
  assign bus_rd_o = (phase == PH_T2) || (phase == PH_TW) || (phase == PH_T3);
endmodule

// File: rtl/ssb_rd_master_chk.sv
module ssb_rd_master_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          bus_rd_o,
  input logic          valid_o,
  input logic          err_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [DW-1:0] rdata_o
);
  a_r3_strobe_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_o |-> busy_o);

  a_r2_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && !bus_rd_o));

  a_r7_valid_as_strobe_drops: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (!bus_rd_o && $past(bus_rd_o)));

  a_r9_err_excludes_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && err_o));

  a_r6_rdata_moves_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata_o) |-> valid_o);

  a_r11_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(bus_addr_o));

  a_r8_busy_ends_after_t4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(valid_o || err_o));
endmodule

bind ssb_rd_master ssb_rd_master_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .bus_rd_o   (bus_rd_o),
  .valid_o    (valid_o),
  .err_o      (err_o),
  .bus_addr_o (bus_addr_o),
  .rdata_o    (rdata_o)
);

// File: tb/test_ssb_rd_master.sv
module test_ssb_rd_master;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int MW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [AW-1:0] addr_i;
  logic          busy_o, valid_o, err_o, bus_rd_o, bus_wait_i;
  logic [DW-1:0] rdata_o, bus_data_i;
  logic [AW-1:0] bus_addr_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int            sl_nwait = 0;
  logic [DW-1:0] sl_data  = '0;
  int            rd_cnt;

  always #5 clk = ~clk;

  ssb_rd_master #(.AW(AW), .DW(DW), .MAX_WAIT(MW)) i_ssb_rd_master (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .addr_i     (addr_i),
    .busy_o     (busy_o),
    .rdata_o    (rdata_o),
    .valid_o    (valid_o),
    .err_o      (err_o),
    .bus_addr_o (bus_addr_o),
    .bus_rd_o   (bus_rd_o),
    .bus_wait_i (bus_wait_i),
    .bus_data_i (bus_data_i)
  );

  // Slave model: not ready for the first sl_nwait samples of a strobe.
  always_ff @(posedge clk) begin
    if (!bus_rd_o) rd_cnt <= 0;
    else           rd_cnt <= rd_cnt + 1;
  end
  assign bus_wait_i = bus_rd_o && (rd_cnt >= sl_nwait);
  assign bus_data_i = (bus_rd_o && bus_wait_i) ? sl_data : 8'h5A;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  logic [DW-1:0] exp_rdata;

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input int n, input int inj);
    bit    ab    = (n > MW);
    int    total = ab ? (3 + MW) : (4 + n);
    string tag;
    sl_nwait = n;
    sl_data  = d;
    @(negedge clk);
    start_i = 1'b1;
    addr_i  = a;
    @(negedge clk);
    for (int c = 1; c <= total + 2; c++) begin
      logic e_busy, e_rd, e_val, e_err;
      logic [AW-1:0] e_addr;
      e_busy = (c <= total);
      e_rd   = (c >= 2) && (c < total);
      e_val  = !ab && (c == total);
      e_err  = ab && (c == total);
      e_addr = e_busy ? a : '0;
      if (e_val) exp_rdata = d;
      if (c > total)                tag = "R8";
      else if (c == total)          tag = ab ? "R9" : "R7";
      else if (c == 1)              tag = "R2";
      else if (c == 2)              tag = (n == 0) ? "R4" : "R3";
      else if (!ab && c == total-1) tag = "R6";
      else                          tag = "R5";
      chk(tag, {12'd0, e_busy, e_rd, e_val, e_err, 8'd0, exp_rdata},
               {12'd0, busy_o, bus_rd_o, valid_o, err_o, 8'd0, rdata_o});
      chk("R11", {24'd0, e_addr}, {24'd0, bus_addr_o});
      if (inj != 0 && c == inj) begin
        start_i = 1'b1;
        addr_i  = ~a;
      end else begin
        start_i = 1'b0;
        addr_i  = a;
      end
      @(negedge clk);
    end
    if (inj != 0)
      chk("R10", {23'd0, busy_o, bus_addr_o}, 32'd0);
  endtask

  initial begin
    rst_n     = 1'b0;
    start_i   = 1'b0;
    addr_i    = '0;
    exp_rdata = '0;
    repeat (3) @(negedge clk);
    chk("R1", {20'd0, busy_o, bus_rd_o, valid_o, err_o, rdata_o}, 32'd0);
    chk("R1", {24'd0, bus_addr_o}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", {20'd0, busy_o, bus_rd_o, valid_o, err_o, rdata_o}, 32'd0);
    for (int n = 0; n <= MW + 2; n++) begin
      for (int k = 0; k < 3; k++) begin
        logic [AW-1:0] a;
        int inj, tot;
        a   = AW'(n * 16 + k + 1);
        tot = (n > MW) ? (3 + MW) : (4 + n);
        inj = (k == 1) ? 2 : (k == 2) ? tot : 0;
        do_read(a, DW'(~a ^ (k * 37)), n, inj);
        chk("R6", {24'd0, rdata_o}, {24'd0, exp_rdata});
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule